// File: doc/BRIEF.md
# Bad block scan engine

The engine surveys every erase block of a NAND flash after power-up and records which blocks carry a factory bad mark. A single pulse on the start input launches the survey. For each block the engine reads one marker byte from page 0 and one from page 1, both at a configurable column. It goes through an external read port that is held until answered. It then stores one flag bit per block in an internal map.

When the survey ends, the map answers block lookups with a one-cycle registered read. It also screens erase requests, so a block that carries a bad mark is never passed on for erasure. A running count of flagged blocks is kept, and an alarm is raised when that count goes above a configured limit.

Top module: `bbt_scan_engine`

## Requirements
- R1: While reset is asserted, busy_o, done_o, rd_req_o, lk_bad_o, alarm_o and bad_cnt_o are all 0.
- R2: A start_i pulse while idle begins a scan, and busy_o rises in the next cycle. Reads are issued in ascending block order, page 0 before page 1 for each block, which gives exactly two reads per block. Each read holds rd_req_o and a stable address until a cycle with rd_rsp_valid_i. After the response for the last block, busy_o falls, done_o rises and no further read is issued.
- R3: The read row address is the block index shifted left by PAGE_BITS, with the page number in bits PAGE_BITS-1:0 (bits 5:0 by default, block in 16:6). The read column is always MARK_COL.
- R4: A block is flagged bad when the marker byte from either of its two pages differs from FFh. Any single cleared bit is enough. A block whose two bytes are both FFh is flagged good.
- R5: lk_bad_o gives, one clock after lk_blk_i is presented, the flag of that block: 1 means bad and 0 means good.
- R6: bad_cnt_o equals the number of blocks flagged in the current scan. alarm_o is 1 exactly when bad_cnt_o is greater than ALARM_LIMIT, and equality does not raise it.
- R7: A start_i pulse while a scan is running is ignored. The read sequence continues unchanged and the final count is unaffected.
- R8: er_req_o is asserted only when er_req_i is asserted, done_o is 1 and the block in er_row_i (its bits above PAGE_BITS) is flagged good. er_row_o always equals er_row_i. er_reject_o is 1 when er_req_i is asserted but the request is withheld.
- R9: A new start_i after done clears every flag, the count and done_o, and then rescans. A block that is now good reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Scan start pulse |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan complete, map valid |
| rd_req_o | output | 1 | Read request, held until response |
| rd_row_o | output | ROW_W | Read row (block, page) |
| rd_col_o | output | COL_W | Read column |
| rd_rsp_valid_i | input | 1 | Read response valid, completes the request |
| rd_rsp_data_i | input | DATA_W | Marker byte returned |
| lk_blk_i | input | BLK_W | Lookup block index |
| lk_bad_o | output | 1 | Lookup result, one cycle later |
| er_req_i | input | 1 | Incoming erase request |
| er_row_i | input | ROW_W | Incoming erase row |
| er_req_o | output | 1 | Erase request forwarded |
| er_row_o | output | ROW_W | Forwarded erase row |
| er_reject_o | output | 1 | Erase request withheld |
| bad_cnt_o | output | CNT_W | Number of bad blocks |
| alarm_o | output | 1 | Bad count above limit |

## Verification
The bench builds the engine with 16 blocks, a marker column of 2048 and an alarm limit of 3. This keeps a full scan at 32 reads, so the table can cover every block. Several marker patterns can then be placed on both pages, on the last block, and on a single cleared bit. With these values a count of 4 raises the alarm, and a rescan with a count of exactly 3 shows that equality leaves it low. The wider 2048-block address layout is kept by leaving PAGE_BITS at 6.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAGE0 = 2'd1,
    ST_PAGE1 = 2'd2
  } scan_st_e;
endpackage

// File: rtl/bbt_row_map.sv
module bbt_row_map #(
  parameter int BLK_W     = 11,
  parameter int PAGE_BITS = 6,
  parameter int COL_W     = 12,
  parameter int MARK_COL  = 0,
  localparam int ROW_W    = BLK_W + PAGE_BITS
) (
  input  logic [BLK_W-1:0] blk_i,
  input  logic             page_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  generate
    if (PAGE_BITS > 1) begin : g_wide
      assign row_o = {blk_i, {(PAGE_BITS-1){1'b0}}, page_i};
    end else begin : g_narrow
      assign row_o = {blk_i, page_i};
    end
  endgenerate

  assign col_o = COL_W'(MARK_COL);
endmodule

// File: rtl/bbt_bitmap.sv
module bbt_bitmap #(
  parameter int NUM_BLOCKS = 2048,
  localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [BLK_W-1:0] wr_blk_i,
  input  logic             wr_bad_i,
  input  logic [BLK_W-1:0] lk_blk_i,
  output logic             lk_bad_o,
  input  logic [BLK_W-1:0] gd_blk_i,
  output logic             gd_bad_o
);
  localparam logic [BLK_W:0] NB = (BLK_W+1)'(NUM_BLOCKS);

  logic [NUM_BLOCKS-1:0] map_q;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  map_q[b] <= 1'b0;
      else if (clr_i)                               map_q[b] <= 1'b0;
      else if (wr_i && wr_blk_i == BLK_W'(b))       map_q[b] <= wr_bad_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lk_bad_o <= 1'b0;
    else         lk_bad_o <= ({1'b0, lk_blk_i} < NB) ? map_q[lk_blk_i] : 1'b0;
  end

  assign gd_bad_o = ({1'b0, gd_blk_i} < NB) ? map_q[gd_blk_i] : 1'b1;
endmodule

// File: rtl/bbt_erase_guard.sv
module bbt_erase_guard #(
  parameter int BLK_W     = 11,
  parameter int PAGE_BITS = 6,
  localparam int ROW_W    = BLK_W + PAGE_BITS
) (
  input  logic             er_req_i,
  input  logic [ROW_W-1:0] er_row_i,
  input  logic             valid_i,
  input  logic             bad_i,
  output logic [BLK_W-1:0] blk_o,
  output logic             er_req_o,
  output logic [ROW_W-1:0] er_row_o,
  output logic             er_reject_o
);
  assign blk_o       = er_row_i[ROW_W-1:PAGE_BITS];
  assign er_row_o    = er_row_i;
  assign er_req_o    = er_req_i & valid_i & ~bad_i;
  assign er_reject_o = er_req_i & ~(valid_i & ~bad_i);
endmodule

// File: rtl/bbt_scan_engine.sv
module bbt_scan_engine
  import bbt_pkg::*;
#(
  parameter int NUM_BLOCKS  = 2048,
  parameter int PAGE_BITS   = 6,
  parameter int COL_W       = 12,
  parameter int MARK_COL    = 0,
  parameter int DATA_W      = 8,
  parameter int ALARM_LIMIT = 40,
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int ROW_W      = BLK_W + PAGE_BITS,
  localparam int CNT_W      = $clog2(NUM_BLOCKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_req_o,
  output logic [ROW_W-1:0]  rd_row_o,
  output logic [COL_W-1:0]  rd_col_o,
  input  logic              rd_rsp_valid_i,
  input  logic [DATA_W-1:0] rd_rsp_data_i,
  input  logic [BLK_W-1:0]  lk_blk_i,
  output logic              lk_bad_o,
  input  logic              er_req_i,
  input  logic [ROW_W-1:0]  er_row_i,
  output logic              er_req_o,
  output logic [ROW_W-1:0]  er_row_o,
  output logic              er_reject_o,
  output logic [CNT_W-1:0]  bad_cnt_o,
  output logic              alarm_o
);
  localparam logic [DATA_W-1:0] ERASED   = {DATA_W{1'b1}};
  localparam logic [BLK_W-1:0]  LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [CNT_W-1:0]  LIMIT    = CNT_W'(ALARM_LIMIT);

  scan_st_e         state_q;
  logic [BLK_W-1:0] blk_q;
  logic             flag_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  logic             start_ok;
  logic             mark_bad;
  logic             commit;
  logic             blk_bad;
  logic [BLK_W-1:0] gd_blk;
  logic             gd_bad;

  assign start_ok = start_i && (state_q == ST_IDLE);
  assign mark_bad = (rd_rsp_data_i != ERASED);
  assign commit   = (state_q == ST_PAGE1) && rd_rsp_valid_i;
  assign blk_bad  = flag_q | mark_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      flag_q  <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            state_q <= ST_PAGE0;
            blk_q   <= '0;
            flag_q  <= 1'b0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
          end
        end
        ST_PAGE0: begin
          if (rd_rsp_valid_i) begin
            flag_q  <= mark_bad;
            state_q <= ST_PAGE1;
          end
        end
        ST_PAGE1: begin
          if (rd_rsp_valid_i) begin
            if (blk_bad) cnt_q <= cnt_q + CNT_W'(1);
            flag_q <= 1'b0;
            if (blk_q == LAST_BLK) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              blk_q   <= blk_q + BLK_W'(1);
              state_q <= ST_PAGE0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign rd_req_o  = busy_o;
  assign bad_cnt_o = cnt_q;
  assign alarm_o   = (cnt_q > LIMIT);

  bbt_row_map #(
    .BLK_W(BLK_W), .PAGE_BITS(PAGE_BITS), .COL_W(COL_W), .MARK_COL(MARK_COL)
  ) u_row (
    .blk_i  (blk_q),
    .page_i (state_q == ST_PAGE1),
    .row_o  (rd_row_o),
    .col_o  (rd_col_o)
  );

  bbt_bitmap #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_ok),
    .wr_i     (commit),
    .wr_blk_i (blk_q),
    .wr_bad_i (blk_bad),
    .lk_blk_i (lk_blk_i),
    .lk_bad_o (lk_bad_o),
    .gd_blk_i (gd_blk),
    .gd_bad_o (gd_bad)
  );

  bbt_erase_guard #(.BLK_W(BLK_W), .PAGE_BITS(PAGE_BITS)) u_guard (
    .er_req_i    (er_req_i),
    .er_row_i    (er_row_i),
    .valid_i     (done_q),
    .bad_i       (gd_bad),
    .blk_o       (gd_blk),
    .er_req_o    (er_req_o),
    .er_row_o    (er_row_o),
    .er_reject_o (er_reject_o)
  );

  // R2: request held with a stable address until answered
  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_rsp_valid_i) |=> (rd_req_o && $stable(rd_row_o)));

  // R3: only pages 0 and 1, fixed marker column
  assert_page_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_row_o[PAGE_BITS-1:0] <= PAGE_BITS'(1) && rd_col_o == COL_W'(MARK_COL)));

  // R6: count never drops and alarm never clears while scanning
  assert_cnt_monotonic_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || bad_cnt_o >= $past(bad_cnt_o)));

  assert_alarm_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && alarm_o) |=> alarm_o);

  // R8: no erase forwarded before the map is complete
  assert_no_erase_unscanned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !er_req_o);

  assert_done_busy_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));
endmodule

// File: tb/sim_bbt_scan_engine.sv
`timescale 1ns/1ps
module sim_bbt_scan_engine;
  localparam int NB    = 16;
  localparam int PB    = 6;
  localparam int CW    = 12;
  localparam int MCOL  = 2048;
  localparam int DW    = 8;
  localparam int LIM   = 3;
  localparam int BW    = $clog2(NB);
  localparam int RW    = BW + PB;
  localparam int KW    = $clog2(NB + 1);
  localparam int LAT   = 3;

  // {page0 byte, page1 byte, expected bad}
  localparam logic [16:0] VEC [NB] = '{
    {8'hFF, 8'hFF, 1'b0}, {8'hFF, 8'hFF, 1'b0}, {8'hFF, 8'hFF, 1'b0}, {8'h00, 8'hFF, 1'b1},
    {8'hFF, 8'hFF, 1'b0}, {8'hFF, 8'h7F, 1'b1}, {8'hFF, 8'hFF, 1'b0}, {8'hFF, 8'hFF, 1'b0},
    {8'hFF, 8'hFF, 1'b0}, {8'hFE, 8'hFE, 1'b1}, {8'hFF, 8'hFF, 1'b0}, {8'hFF, 8'hFF, 1'b0},
    {8'hFF, 8'hFF, 1'b0}, {8'hFF, 8'hFF, 1'b0}, {8'hFF, 8'hFF, 1'b0}, {8'hFF, 8'h00, 1'b1}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic busy, done, rd_req, rsp_v = 0;
  logic [RW-1:0] rd_row;
  logic [CW-1:0] rd_col;
  logic [DW-1:0] rsp_d = '0;
  logic [BW-1:0] lk_blk = '0;
  logic lk_bad;
  logic er_req = 0;
  logic [RW-1:0] er_row = '0;
  logic er_req_o, er_rej;
  logic [RW-1:0] er_row_o;
  logic [KW-1:0] cnt;
  logic alarm;

  int tests = 0, fails = 0;
  int seq = 0, wcnt = 0, order_err = 0;
  bit pass2 = 0;

  always #4 clk = ~clk;

  bbt_scan_engine #(
    .NUM_BLOCKS(NB), .PAGE_BITS(PB), .COL_W(CW), .MARK_COL(MCOL),
    .DATA_W(DW), .ALARM_LIMIT(LIM)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .rd_req_o(rd_req), .rd_row_o(rd_row), .rd_col_o(rd_col),
    .rd_rsp_valid_i(rsp_v), .rd_rsp_data_i(rsp_d),
    .lk_blk_i(lk_blk), .lk_bad_o(lk_bad),
    .er_req_i(er_req), .er_row_i(er_row), .er_req_o(er_req_o),
    .er_row_o(er_row_o), .er_reject_o(er_rej),
    .bad_cnt_o(cnt), .alarm_o(alarm)
  );

  function automatic logic [7:0] marker(int b, int p);
    if (pass2 && b == NB - 1) return 8'hFF;
    return (p == 0) ? VEC[b][16:9] : VEC[b][8:1];
  endfunction

  // flash read model, driven away from the active edge
  always @(negedge clk) begin
    if (rsp_v) begin
      rsp_v = 0;
    end else if (rd_req) begin
      if (wcnt == LAT - 1) begin
        int eb, ep;
        eb = seq / 2;
        ep = seq % 2;
        if (eb >= NB || rd_row != RW'((eb << PB) | ep) || rd_col != CW'(MCOL))
          order_err++;
        rsp_d = marker(int'(rd_row) >> PB, int'(rd_row) & 1);
        rsp_v = 1;
        wcnt  = 0;
        seq++;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
  endtask

  task automatic erase_try(input int b, input int p, input bit exp_fwd, input string req);
    @(negedge clk);
    er_req = 1;
    er_row = RW'((b << PB) | p);
    #1;
    chk(er_req_o == exp_fwd, req, er_req_o, exp_fwd);
    chk(er_rej == !exp_fwd, req, er_rej, !exp_fwd);
    chk(er_row_o == er_row, req, er_row_o, er_row);
    er_req = 0;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(rd_req == 0, "R1 rd_req", rd_req, 0);
    chk(lk_bad == 0, "R1 lk_bad", lk_bad, 0);
    chk(alarm == 0 && cnt == 0, "R1 cnt/alarm", cnt, 0);
    @(negedge clk) rst_n = 1;

    // R8 erase before any scan is withheld
    erase_try(1, 0, 0, "R8 unscanned");

    // R2 first scan
    seq = 0;
    pulse_start();
    chk(busy == 1, "R2 busy after start", busy, 1);
    // R7 start while busy
    repeat (20) @(negedge clk);
    pulse_start();
    wait_done();
    @(negedge clk);
    chk(done == 1, "R2 done", done, 1);
    chk(busy == 0, "R2 busy cleared", busy, 0);
    chk(seq == 2 * NB, "R2 R7 read count", seq, 2 * NB);
    chk(order_err == 0, "R2 R3 R7 read order/address", order_err, 0);
    repeat (5) @(negedge clk);
    chk(rd_req == 0 && seq == 2 * NB, "R2 no reads after done", seq, 2 * NB);
    chk(cnt == 4, "R6 R7 bad count", cnt, 4);
    chk(alarm == 1, "R6 alarm above limit", alarm, 1);

    // R4 R5 lookup walk over table
    for (int i = 0; i < NB; i++) begin
      @(negedge clk) lk_blk = BW'(i);
      @(negedge clk);
      chk(lk_bad == VEC[i][0], $sformatf("R4 R5 block %0d", i), lk_bad, VEC[i][0]);
    end

    // R8 guard after scan
    erase_try(1, 0, 1, "R8 good block");
    erase_try(3, 0, 0, "R8 bad block page0");
    erase_try(5, 33, 0, "R8 bad block other page");
    erase_try(15, 63, 0, "R8 last block bad");
    erase_try(0, 5, 1, "R8 block0 good");

    // R9 rescan with last block now good
    pass2 = 1;
    seq = 0;
    pulse_start();
    chk(done == 0, "R9 done cleared", done, 0);
    chk(cnt == 0, "R9 count cleared", cnt, 0);
    wait_done();
    @(negedge clk);
    chk(seq == 2 * NB && order_err == 0, "R9 rescan reads", seq, 2 * NB);
    chk(cnt == 3, "R9 R6 count", cnt, 3);
    chk(alarm == 0, "R6 alarm at limit", alarm, 0);
    @(negedge clk) lk_blk = BW'(NB - 1);
    @(negedge clk);
    chk(lk_bad == 0, "R9 cleared flag", lk_bad, 0);
    @(negedge clk) lk_blk = BW'(9);
    @(negedge clk);
    chk(lk_bad == 1, "R9 R4 kept flag", lk_bad, 1);
    erase_try(15, 0, 1, "R9 R8 last block now good");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule